// File: doc/BRIEF.md
# Far Call Target Descriptor Checker

This block decides, for a protected-mode far call, what kind of target the selected descriptor is and whether the call may proceed. It takes the selector from the call operand, the limit of the descriptor table that selector points into, the already-fetched type, privilege level and present flag of that descriptor, and the current privilege level. It returns either the call path to follow or a fault kind with the selector to report as the error code.

When the target is a task gate, the block also screens the task-state reference carried by that gate. That descriptor has already been fetched elsewhere. Memory reads and the task switch itself are not part of this block. Every rule has a fixed rank, and only the first one that fails is reported. The result is registered and appears one clock after the request. A build parameter can make the block purely combinational instead.

Top module: `fcall_desc_check`

## Requirements
- R1: A selector whose index is 0 and whose table bit is 0 gives a general-protection fault with error selector 0, whatever its RPL. Selector layout: bits [1:0] are RPL, bit 2 is the table bit (1 = local table), and the bits above are the index. Fault codes: 0 none, 1 general-protection, 2 not-present.
- R2: An index greater than `in_tbl_limit` gives a general-protection fault. The limit is the highest valid index. The error selector is the index and table bit with bits [1:0] forced to 0; every selector-carrying fault uses this format.
- R3: Type coding is 5 bits. Bit 4 set means a memory segment. With bit 4 set, bit 3 set means code and bit 2 then means conforming. System types are 00100 or 01100 for a call gate, 00101 for a task gate, 00001 or 01001 for an available task-state segment, and 00011 or 01011 for a busy one. Any other type, including data segments, gives a general-protection fault with the selector.
- R4: For conforming code, DPL greater than CPL gives a general-protection fault with the selector.
- R5: For nonconforming code, RPL greater than CPL, or DPL not equal to CPL, gives a general-protection fault with the selector.
- R6: For a call gate, task gate or task-state segment, DPL below CPL or DPL below RPL gives a general-protection fault with the selector. A busy task-state segment named directly also faults this way.
- R7: A descriptor that passes R1 to R6 and has its present flag clear gives a not-present fault with the selector.
- R8: For a present task gate that passes R6, the linked task-state reference is checked next. A table bit of 1, or an index above `in_gdt_limit`, gives a general-protection fault. A linked type other than 00001 or 01001 also gives a general-protection fault. A clear linked present flag gives a not-present fault. Each of these reports the linked index and table bit as the error selector.
- R9: When no check fails, the fault is 0 and the path code is one of: 1 conforming code, 2 nonconforming code, 3 call gate, 4 task gate, 5 task-state segment. For the two code paths, `out_cs` is the selector with RPL replaced by CPL; for every other result it is 0.
- R10: The checks are ranked R1, R2, R3, then the class rule (R4, R5 or R6), then R7, then R8. Only the first failure is reported.
- R11: With `REG_OUT` = 1, the result for a request appears on the outputs one clock after `in_valid`. If there was no request, and during reset, `out_valid` is 0 and the fault, path, error selector and `out_cs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request qualifier |
| in_sel | input | IDX_W+3 | Target selector: index, table bit, RPL |
| in_tbl_limit | input | IDX_W | Highest valid index of the addressed table |
| in_type | input | 5 | Descriptor type code |
| in_dpl | input | 2 | Descriptor privilege level |
| in_present | input | 1 | Descriptor present flag |
| in_cpl | input | 2 | Current privilege level |
| in_link_ref | input | IDX_W+1 | Task-gate reference: index and table bit (bit 0) |
| in_gdt_limit | input | IDX_W | Highest valid index of the global table |
| in_link_type | input | 5 | Type code of the referenced task-state descriptor |
| in_link_present | input | 1 | Present flag of the referenced task-state descriptor |
| out_valid | output | 1 | Result qualifier |
| out_fault | output | 2 | Fault kind: 0 none, 1 general-protection, 2 not-present |
| out_path | output | 3 | Path code (0 when a fault is reported) |
| out_err_sel | output | IDX_W+3 | Selector to report as the error code |
| out_cs | output | IDX_W+3 | Code selector to load, RPL forced to CPL |

## Verification
The hardest cases to reach are the task-gate reference faults of R8. They are only visible when the gate itself passes every earlier rank, and any stray earlier failure hides them. The bench therefore holds a gate that passes all earlier ranks, present and with DPL 3 at CPL 0, and sweeps every link reference, link type and link present value under two global-table limits. A second sweep crosses every type, DPL, CPL, RPL and present value, so the priority between class rules and the not-present check is covered. A third sweep crosses all selectors with all table limits.

// File: rtl/fcall_pkg.sv
package fcall_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_NP   = 2'd2
   } fault_e;

   typedef enum logic [2:0] {
      PATH_NONE  = 3'd0,
      PATH_CONF  = 3'd1,
      PATH_NCONF = 3'd2,
      PATH_CGATE = 3'd3,
      PATH_TGATE = 3'd4,
      PATH_TSS   = 3'd5
   } path_e;

   typedef enum logic [2:0] {
      CLS_BAD,
      CLS_CONF,
      CLS_NCONF,
      CLS_CGATE,
      CLS_TGATE,
      CLS_TSS_FREE,
      CLS_TSS_BUSY
   } dclass_e;

   localparam int TYPE_W = 5;

   function automatic dclass_e classify(input logic [TYPE_W-1:0] t);
      dclass_e c;
      c = CLS_BAD;
      if (t[4]) begin
         if (t[3]) c = t[2] ? CLS_CONF : CLS_NCONF;
      end else begin
         case (t[3:0])
            4'b0100, 4'b1100: c = CLS_CGATE;
            4'b0101:          c = CLS_TGATE;
            4'b0001, 4'b1001: c = CLS_TSS_FREE;
            4'b0011, 4'b1011: c = CLS_TSS_BUSY;
            default:          c = CLS_BAD;
         endcase
      end
      return c;
   endfunction

   function automatic logic tss_free(input logic [TYPE_W-1:0] t);
      return classify(t) == CLS_TSS_FREE;
   endfunction

endpackage

// File: rtl/fcall_sel_screen.sv
module fcall_sel_screen #(
   parameter int IDX_W       = 13,
   parameter bit CHECK_NULL  = 1'b1,
   parameter bit GLOBAL_ONLY = 1'b0
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             ti,
   input  logic [IDX_W-1:0] limit,
   output logic             is_null,
   output logic             bad_ref
);
   logic over;

   assign over = idx > limit;

   generate
      if (CHECK_NULL) begin : g_null
         assign is_null = (idx == '0) && !ti;
      end else begin : g_no_null
         assign is_null = 1'b0;
      end

      if (GLOBAL_ONLY) begin : g_glob
         assign bad_ref = over || ti;
      end else begin : g_any
         assign bad_ref = over;
      end
   endgenerate

endmodule

// File: rtl/fcall_priv_rule.sv
module fcall_priv_rule
   import fcall_pkg::*;
(
   input  logic [TYPE_W-1:0] dtype,
   input  logic [1:0]        dpl,
   input  logic [1:0]        rpl,
   input  logic [1:0]        cpl,
   output dclass_e           cls,
   output logic              priv_fail
);
   logic gate_low;

   assign cls      = classify(dtype);
   assign gate_low = (dpl < cpl) || (dpl < rpl);

   always_comb begin
      priv_fail = 1'b0;
      case (cls)
         CLS_CONF:     priv_fail = dpl > cpl;
         CLS_NCONF:    priv_fail = (rpl > cpl) || (dpl != cpl);
         CLS_CGATE,
         CLS_TGATE,
         CLS_TSS_FREE: priv_fail = gate_low;
         CLS_TSS_BUSY: priv_fail = 1'b1;
         default:      priv_fail = 1'b0;
      endcase
   end

endmodule

// File: rtl/fcall_link_check.sv
module fcall_link_check
   import fcall_pkg::*;
#(
   parameter int IDX_W = 13,
   localparam int REF_W = IDX_W + 1,
   localparam int SEL_W = IDX_W + 3
) (
   input  logic [REF_W-1:0]  link_ref,
   input  logic [IDX_W-1:0]  gdt_limit,
   input  logic [TYPE_W-1:0] link_type,
   input  logic              link_present,
   output fault_e            fault,
   output logic [SEL_W-1:0]  err_sel
);
   logic link_null;
   logic link_bad;

   fcall_sel_screen #(
      .IDX_W       (IDX_W),
      .CHECK_NULL  (1'b0),
      .GLOBAL_ONLY (1'b1)
   ) u_screen (
      .idx     (link_ref[REF_W-1:1]),
      .ti      (link_ref[0]),
      .limit   (gdt_limit),
      .is_null (link_null),
      .bad_ref (link_bad)
   );

   assign err_sel = {link_ref, 2'b00};

   always_comb begin
      if (link_null || link_bad)      fault = FLT_GP;
      else if (!tss_free(link_type))  fault = FLT_GP;
      else if (!link_present)         fault = FLT_NP;
      else                            fault = FLT_NONE;
   end

endmodule

// File: rtl/fcall_desc_check.sv
module fcall_desc_check
   import fcall_pkg::*;
#(
   parameter int IDX_W   = 13,
   parameter bit REG_OUT = 1'b1,
   localparam int SEL_W = IDX_W + 3,
   localparam int REF_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SEL_W-1:0] in_sel,
   input  logic [IDX_W-1:0] in_tbl_limit,
   input  logic [4:0]       in_type,
   input  logic [1:0]       in_dpl,
   input  logic             in_present,
   input  logic [1:0]       in_cpl,
   input  logic [REF_W-1:0] in_link_ref,
   input  logic [IDX_W-1:0] in_gdt_limit,
   input  logic [4:0]       in_link_type,
   input  logic             in_link_present,
   output logic             out_valid,
   output logic [1:0]       out_fault,
   output logic [2:0]       out_path,
   output logic [SEL_W-1:0] out_err_sel,
   output logic [SEL_W-1:0] out_cs
);
   generate
      if (IDX_W < 1 || IDX_W > 13) begin : g_bad_idx
         $error("fcall_desc_check: IDX_W must lie in 1..13");
      end
   endgenerate

   logic             sel_null;
   logic             sel_bad;
   dclass_e          cls;
   logic             priv_fail;
   fault_e           link_fault;
   logic [SEL_W-1:0] link_err;
   logic [SEL_W-1:0] sel_err;

   fault_e           nxt_fault;
   path_e            nxt_path;
   logic [SEL_W-1:0] nxt_err;
   logic [SEL_W-1:0] nxt_cs;

   fcall_sel_screen #(
      .IDX_W       (IDX_W),
      .CHECK_NULL  (1'b1),
      .GLOBAL_ONLY (1'b0)
   ) u_screen (
      .idx     (in_sel[SEL_W-1:3]),
      .ti      (in_sel[2]),
      .limit   (in_tbl_limit),
      .is_null (sel_null),
      .bad_ref (sel_bad)
   );

   fcall_priv_rule u_priv (
      .dtype     (in_type),
      .dpl       (in_dpl),
      .rpl       (in_sel[1:0]),
      .cpl       (in_cpl),
      .cls       (cls),
      .priv_fail (priv_fail)
   );

   fcall_link_check #(.IDX_W(IDX_W)) u_link (
      .link_ref     (in_link_ref),
      .gdt_limit    (in_gdt_limit),
      .link_type    (in_link_type),
      .link_present (in_link_present),
      .fault        (link_fault),
      .err_sel      (link_err)
   );

   assign sel_err = {in_sel[SEL_W-1:2], 2'b00};

   // fixed-rank resolution: first failing rule wins
   always_comb begin
      nxt_fault = FLT_NONE;
      nxt_path  = PATH_NONE;
      nxt_err   = '0;
      nxt_cs    = '0;
      if (in_valid) begin
         if (sel_null) begin
            nxt_fault = FLT_GP;
         end else if (sel_bad || cls == CLS_BAD || priv_fail) begin
            nxt_fault = FLT_GP;
            nxt_err   = sel_err;
         end else if (!in_present) begin
            nxt_fault = FLT_NP;
            nxt_err   = sel_err;
         end else if (cls == CLS_TGATE && link_fault != FLT_NONE) begin
            nxt_fault = link_fault;
            nxt_err   = link_err;
         end else begin
            case (cls)
               CLS_CONF:  nxt_path = PATH_CONF;
               CLS_NCONF: nxt_path = PATH_NCONF;
               CLS_CGATE: nxt_path = PATH_CGATE;
               CLS_TGATE: nxt_path = PATH_TGATE;
               default:   nxt_path = PATH_TSS;
            endcase
            if (cls == CLS_CONF || cls == CLS_NCONF)
               nxt_cs = {in_sel[SEL_W-1:2], in_cpl};
         end
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               out_fault   <= '0;
               out_path    <= '0;
               out_err_sel <= '0;
               out_cs      <= '0;
            end else begin
               out_valid   <= in_valid;
               out_fault   <= nxt_fault;
               out_path    <= nxt_path;
               out_err_sel <= nxt_err;
               out_cs      <= nxt_cs;
            end
         end
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign out_fault   = nxt_fault;
         assign out_path    = nxt_path;
         assign out_err_sel = nxt_err;
         assign out_cs      = nxt_cs;
      end
   endgenerate

endmodule

// File: rtl/fcall_desc_check_sva.sv
module fcall_desc_check_sva #(
   parameter int IDX_W   = 13,
   parameter bit REG_OUT = 1'b1,
   localparam int SEL_W = IDX_W + 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] in_sel,
   input logic [1:0]       in_dpl,
   input logic             in_present,
   input logic [1:0]       in_cpl,
   input logic             out_valid,
   input logic [1:0]       out_fault,
   input logic [2:0]       out_path,
   input logic [SEL_W-1:0] out_err_sel,
   input logic [SEL_W-1:0] out_cs
);
   logic [SEL_W-1:0] a_sel;
   logic [1:0]       a_dpl;
   logic [1:0]       a_cpl;
   logic             a_present;

   generate
      if (REG_OUT) begin : g_align
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_sel <= '0; a_dpl <= '0; a_cpl <= '0; a_present <= 1'b0;
            end else begin
               a_sel <= in_sel; a_dpl <= in_dpl; a_cpl <= in_cpl; a_present <= in_present;
            end
         end
      end else begin : g_direct
         assign a_sel     = in_sel;
         assign a_dpl     = in_dpl;
         assign a_cpl     = in_cpl;
         assign a_present = in_present;
      end
   endgenerate

   a_r1_null_code0: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && a_sel[SEL_W-1:2] == '0) |-> (out_fault == 2'd1 && out_err_sel == '0));

   a_r4_conf_dpl: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 2'd0 && out_path == 3'd1) |-> (a_dpl <= a_cpl));

   a_r5_nconf_rule: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 2'd0 && out_path == 3'd2)
      |-> (a_dpl == a_cpl && a_sel[1:0] <= a_cpl));

   a_r6_gate_rule: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 2'd0 && out_path >= 3'd3)
      |-> (a_dpl >= a_cpl && a_dpl >= a_sel[1:0]));

   a_r7_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !a_present) |-> (out_fault != 2'd0));

   a_r9_cs_rpl: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 2'd0 && (out_path == 3'd1 || out_path == 3'd2))
      |-> (out_cs == {a_sel[SEL_W-1:2], a_cpl}));

   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_fault == 2'd0 && out_path == 3'd0 && out_err_sel == '0 && out_cs == '0));

endmodule

bind fcall_desc_check fcall_desc_check_sva #(.IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/fcall_desc_check_tb.sv
module fcall_desc_check_tb;
   localparam int IW = 3;
   localparam int SW = IW + 3;
   localparam int RW = IW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_sel = '0;
   logic [IW-1:0] in_tbl_limit = '0;
   logic [4:0]    in_type = '0;
   logic [1:0]    in_dpl = '0;
   logic          in_present = 1'b0;
   logic [1:0]    in_cpl = '0;
   logic [RW-1:0] in_link_ref = '0;
   logic [IW-1:0] in_gdt_limit = '0;
   logic [4:0]    in_link_type = '0;
   logic          in_link_present = 1'b0;
   logic          out_valid;
   logic [1:0]    out_fault;
   logic [2:0]    out_path;
   logic [SW-1:0] out_err_sel;
   logic [SW-1:0] out_cs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fcall_desc_check #(.IDX_W(IW), .REG_OUT(1'b1)) u_dut (.*);

   // bench-side type classes: 0 bad,1 conf,2 nconf,3 cgate,4 tgate,5 tss free,6 tss busy
   function automatic int tclass(input logic [4:0] t);
      if (t[4]) return t[3] ? (t[2] ? 1 : 2) : 0;
      case (t[3:0])
         4'b0100, 4'b1100: return 3;
         4'b0101:          return 4;
         4'b0001, 4'b1001: return 5;
         4'b0011, 4'b1011: return 6;
         default:          return 0;
      endcase
   endfunction

   task automatic expect_of(output logic [1:0] f, output logic [2:0] p,
                            output logic [SW-1:0] e, output logic [SW-1:0] c,
                            output string tag);
      int k;
      int rpl;
      int dpl;
      int cpl;
      bit bad;
      k = tclass(in_type); rpl = in_sel[1:0]; dpl = in_dpl; cpl = in_cpl;
      f = 0; p = 0; e = '0; c = '0; tag = "R9";
      if (in_sel[SW-1:2] == '0) begin f = 1; tag = "R1"; return; end
      if (in_sel[SW-1:3] > in_tbl_limit) begin f = 1; e = {in_sel[SW-1:2], 2'b00}; tag = "R2"; return; end
      if (k == 0) begin f = 1; e = {in_sel[SW-1:2], 2'b00}; tag = "R3"; return; end
      case (k)
         1: begin bad = dpl > cpl; tag = "R4"; end
         2: begin bad = (rpl > cpl) || (dpl != cpl); tag = "R5"; end
         6: begin bad = 1'b1; tag = "R6"; end
         default: begin bad = (dpl < cpl) || (dpl < rpl); tag = "R6"; end
      endcase
      if (bad) begin f = 1; e = {in_sel[SW-1:2], 2'b00}; return; end
      if (!in_present) begin f = 2; e = {in_sel[SW-1:2], 2'b00}; tag = "R7"; return; end
      if (k == 4) begin
         e = {in_link_ref, 2'b00}; tag = "R8";
         if (in_link_ref[0] || in_link_ref[RW-1:1] > in_gdt_limit) begin f = 1; return; end
         if (tclass(in_link_type) != 5) begin f = 1; return; end
         if (!in_link_present) begin f = 2; return; end
         e = '0;
      end
      tag = "R9";
      p = (k == 5) ? 3'd5 : 3'(k);
      if (k == 1 || k == 2) c = {in_sel[SW-1:2], in_cpl};
   endtask

   task automatic check_now(input logic [1:0] f, input logic [2:0] p,
                            input logic [SW-1:0] e, input logic [SW-1:0] c,
                            input logic v, input string tag);
      checks++;
      if (out_valid !== v || out_fault !== f || out_path !== p || out_err_sel !== e || out_cs !== c) begin
         errors++;
         $display("FAIL %s: got v=%0b f=%0d p=%0d err=%0h cs=%0h exp v=%0b f=%0d p=%0d err=%0h cs=%0h",
                  tag, out_valid, out_fault, out_path, out_err_sel, out_cs, v, f, p, e, c);
      end
   endtask

   // apply the current inputs as a request, then check one clock later (R11 latency)
   task automatic run_one();
      logic [1:0] f; logic [2:0] p; logic [SW-1:0] e; logic [SW-1:0] c; string tag;
      expect_of(f, p, e, c, tag);
      in_valid = 1'b1;
      @(negedge clk);
      check_now(f, p, e, c, 1'b1, tag);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_now(2'd0, 3'd0, '0, '0, 1'b0, "R11 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // sweep A: all selectors x all table limits, nonconforming code DPL=CPL=1 (R1 R2 R5 R9)
      in_type = 5'b11010; in_dpl = 2'd1; in_cpl = 2'd1; in_present = 1'b1;
      for (int s = 0; s < (1 << SW); s++)
         for (int l = 0; l < (1 << IW); l++) begin
            in_sel = SW'(s); in_tbl_limit = IW'(l);
            run_one();
         end

      // idle with faulting inputs: nothing reported (R11)
      in_valid = 1'b0; in_sel = '0;
      @(negedge clk);
      check_now(2'd0, 3'd0, '0, '0, 1'b0, "R11 idle");

      // sweep B: every type, DPL, CPL, RPL, present (R3 R4 R5 R6 R7 R9 R10)
      in_tbl_limit = IW'(7); in_link_ref = {IW'(2), 1'b0}; in_gdt_limit = IW'(7);
      in_link_type = 5'b01001; in_link_present = 1'b1;
      for (int t = 0; t < 32; t++)
         for (int d = 0; d < 4; d++)
            for (int cp = 0; cp < 4; cp++)
               for (int r = 0; r < 4; r++)
                  for (int pr = 0; pr < 2; pr++) begin
                     in_type = 5'(t); in_dpl = 2'(d); in_cpl = 2'(cp);
                     in_sel = {IW'(5), 1'b1, 2'(r)}; in_present = pr[0];
                     run_one();
                  end

      // sweep C: passing task gate, every link reference/type/present, two global limits (R8 R10)
      in_type = 5'b00101; in_dpl = 2'd3; in_cpl = 2'd0; in_present = 1'b1;
      in_sel = {IW'(1), 1'b0, 2'd0};
      for (int g = 0; g < 2; g++)
         for (int lr = 0; lr < (1 << RW); lr++)
            for (int lt = 0; lt < 32; lt++)
               for (int lp = 0; lp < 2; lp++) begin
                  in_gdt_limit = (g == 0) ? IW'(2) : IW'(7);
                  in_link_ref = RW'(lr); in_link_type = 5'(lt); in_link_present = lp[0];
                  run_one();
               end

      in_valid = 1'b0;
      @(negedge clk);
      check_now(2'd0, 3'd0, '0, '0, 1'b0, "R11 end idle");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule